// File: doc/BRIEF.md
# Changeable Combination Lock Controller

This block guards a stored code word and compares it, every cycle, against a word set on a row of switches. The stored code is always shown on an output bus, and a match flag is raised while the switches equal it. A user who already knows the code may rewrite it. Setting the switches to the present code and pressing the change key opens an edit session. While the key stays pressed, the register follows the switches on every clock edge, so the user can walk the switches to any new value. Releasing the key ends the session and keeps the last value loaded.

Switch and key inputs are taken to be synchronous to the clock already. Debouncing and display driving sit outside this block. A synchronous, active-high reset reloads a fixed default code, closes any open session and holds both flags low.

The code width, the default code, the polarity of the key and the comparator structure are parameters.

Top module: `combo_lock`

## Requirements
- R1: A rising clock edge with `rst` high loads the default code (0x55 for the default parameters) into the register, and `code_o` shows it from the next cycle.
- R2: While `rst` is high, `match_o` and `chg_o` are both 0, whatever the switches and key are.
- R3: With `rst` low, `match_o` is 1 exactly when `sw_i` equals `code_o`.
- R4: The key is active low, so `key_i` = 0 means pressed. A clock edge that sees a match with the key pressed loads `sw_i` into the code register and opens an edit session.
- R5: While a session is open and the key stays pressed, every clock edge loads `sw_i`, even when it differs from the stored code. An edge that sees the key released (`key_i` = 1) closes the session.
- R6: A pressed key with no match and no open session leaves the code unchanged, and `chg_o` stays 0.
- R7: With `rst` low, `chg_o` is 1 exactly when the key is pressed and either a match holds or a session is open.
- R8: An edge that sees the key released never changes the code.
- R9: Reset wins over a load in the same cycle, and it closes an open session, so a held key after reset cannot rewrite the code without a new match.
- R10: `code_o` is the registered code. A load decided in a cycle is seen on `code_o` only after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sw_i | input | 8 | Switch word to compare and to load |
| key_i | input | 1 | Change key, 0 = pressed |
| code_o | output | 8 | Stored code, shown continuously |
| match_o | output | 1 | Switches equal the stored code |
| chg_o | output | 1 | A code load is taking place this cycle |

## Verification
The checker watches the flag rules on every cycle: both flags quiet in reset, the match flag tracking the equality, and `chg_o` never raised without a pressed key. On every cycle it also checks that a raised `chg_o` leads to `sw_i` on the code bus one edge later, and that a released key or an idle cycle leaves the code stable. Only the bench scenarios show the whole sequence of a session. They show a session opening on a match, following switches that no longer match, closing on release, and then rejecting the old code. They also show that a reset in the middle of a held key leaves the session closed afterwards.

// File: rtl/lock_pkg.sv
package lock_pkg;

   // State of the code edit session.
   typedef enum logic {
      EDIT_IDLE = 1'b0,
      EDIT_OPEN = 1'b1
   } edit_e;

   // Maps the raw key level to a "pressed" flag for either polarity.
   function automatic logic key_is_pressed(input logic key, input bit active_low);
      return active_low ? ~key : key;
   endfunction

endpackage

// File: rtl/lock_match.sv
module lock_match #(
   parameter int W    = 8,
   parameter int IMPL = 0   // 0: xor then nor reduction, 1: equality operator
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         eq_o
);

   generate
      if (IMPL == 0) begin : g_xor
         logic [W-1:0] diff;
         assign diff = a_i ^ b_i;
         assign eq_o = ~|diff;
      end else begin : g_eq
         assign eq_o = (a_i == b_i);
      end
   endgenerate

endmodule

// File: rtl/lock_code_store.sv
module lock_code_store
   import lock_pkg::*;
#(
   parameter int             W        = 8,
   parameter logic [W-1:0]   DEF_CODE = 8'h55
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] sw_i,
   output logic [W-1:0] code_o,
   output logic         open_o
);

   logic [W-1:0] code_q;
   edit_e        edit_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= DEF_CODE;
         edit_q <= EDIT_IDLE;
      end else begin
         if (load_i) begin
            code_q <= sw_i;
         end
         edit_q <= load_i ? EDIT_OPEN : EDIT_IDLE;
      end
   end

   assign code_o = code_q;
   assign open_o = (edit_q == EDIT_OPEN);

endmodule

// File: rtl/lock_flags.sv
module lock_flags (
   input  logic rst,
   input  logic eq_i,
   input  logic pressed_i,
   input  logic open_i,
   output logic load_o,
   output logic match_o,
   output logic chg_o
);

   logic allow;

   always_comb begin
      allow   = eq_i | open_i;
      load_o  = pressed_i & allow;
      match_o = ~rst & eq_i;
      chg_o   = ~rst & load_o;
   end

endmodule

// File: rtl/combo_lock.sv
module combo_lock
   import lock_pkg::*;
#(
   parameter int                  CODE_W         = 8,
   parameter logic [CODE_W-1:0]   DEFAULT_CODE   = 8'h55,
   parameter bit                  KEY_ACTIVE_LOW = 1'b1,
   parameter int                  MATCH_IMPL     = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] sw_i,
   input  logic              key_i,
   output logic [CODE_W-1:0] code_o,
   output logic              match_o,
   output logic              chg_o
);

   generate
      if (CODE_W < 1) begin : g_bad_width
         $error("combo_lock: CODE_W must be at least 1");
      end
      if (MATCH_IMPL != 0 && MATCH_IMPL != 1) begin : g_bad_impl
         $error("combo_lock: MATCH_IMPL must be 0 or 1");
      end
   endgenerate

   logic eq;
   logic pressed;
   logic open_s;
   logic load;

   assign pressed = key_is_pressed(key_i, KEY_ACTIVE_LOW);

   lock_match #(
      .W    (CODE_W),
      .IMPL (MATCH_IMPL)
   ) u_match (
      .a_i  (sw_i),
      .b_i  (code_o),
      .eq_o (eq)
   );

   lock_flags u_flags (
      .rst       (rst),
      .eq_i      (eq),
      .pressed_i (pressed),
      .open_i    (open_s),
      .load_o    (load),
      .match_o   (match_o),
      .chg_o     (chg_o)
   );

   lock_code_store #(
      .W        (CODE_W),
      .DEF_CODE (DEFAULT_CODE)
   ) u_store (
      .clk    (clk),
      .rst    (rst),
      .load_i (load),
      .sw_i   (sw_i),
      .code_o (code_o),
      .open_o (open_s)
   );

endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
   parameter int                  CODE_W         = 8,
   parameter logic [CODE_W-1:0]   DEFAULT_CODE   = 8'h55,
   parameter bit                  KEY_ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [CODE_W-1:0] sw_i,
   input logic              key_i,
   input logic [CODE_W-1:0] code_o,
   input logic              match_o,
   input logic              chg_o
);

   logic pressed;
   assign pressed = KEY_ACTIVE_LOW ? ~key_i : key_i;

   p_default_after_reset_r1: assert property (@(posedge clk)
      rst |=> (code_o == DEFAULT_CODE));

   p_quiet_in_reset_r2: assert property (@(posedge clk)
      rst |-> (!match_o && !chg_o));

   p_match_tracks_r3: assert property (@(posedge clk) disable iff (rst)
      match_o == (sw_i == code_o));

   p_match_press_loads_r4: assert property (@(posedge clk) disable iff (rst)
      (match_o && pressed) |=> (code_o == $past(sw_i)));

   p_session_loads_r5: assert property (@(posedge clk) disable iff (rst)
      chg_o |=> (code_o == $past(sw_i)));

   p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
      (!match_o && !chg_o) |=> $stable(code_o));

   p_chg_needs_press_r7: assert property (@(posedge clk) disable iff (rst)
      chg_o |-> pressed);

   p_release_holds_r8: assert property (@(posedge clk) disable iff (rst)
      !pressed |=> $stable(code_o));

endmodule

bind combo_lock combo_lock_chk #(
   .CODE_W         (CODE_W),
   .DEFAULT_CODE   (DEFAULT_CODE),
   .KEY_ACTIVE_LOW (KEY_ACTIVE_LOW)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .sw_i    (sw_i),
   .key_i   (key_i),
   .code_o  (code_o),
   .match_o (match_o),
   .chg_o   (chg_o)
);

// File: tb/sim_combo_lock.sv
module sim_combo_lock;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] sw  = 8'h55;
   logic       key = 1'b0;
   logic [7:0] code;
   logic       match;
   logic       chg;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   combo_lock u0 (
      .clk     (clk),
      .rst     (rst),
      .sw_i    (sw),
      .key_i   (key),
      .code_o  (code),
      .match_o (match),
      .chg_o   (chg)
   );

   // Vector: {sw[7:0], key, exp_match, exp_chg, exp_code_after_edge[7:0]}
   localparam int NV = 11;
   localparam logic [18:0] VEC [NV] = '{
      {8'h55, 1'b1, 1'b1, 1'b0, 8'h55},  // match, released: hold      R3 R8
      {8'h54, 1'b0, 1'b0, 1'b0, 8'h55},  // press, no match            R6
      {8'h55, 1'b0, 1'b1, 1'b1, 8'h55},  // open session               R4
      {8'h3C, 1'b0, 1'b0, 1'b1, 8'h3C},  // session follows switches   R5
      {8'h3C, 1'b0, 1'b1, 1'b1, 8'h3C},
      {8'h3C, 1'b1, 1'b1, 1'b0, 8'h3C},  // release closes session     R5 R8
      {8'h55, 1'b0, 1'b0, 1'b0, 8'h3C},  // old code rejected          R6
      {8'h3C, 1'b0, 1'b1, 1'b1, 8'h3C},  // reopen                     R4
      {8'h81, 1'b0, 1'b0, 1'b1, 8'h81},  //                            R5 R7
      {8'h81, 1'b1, 1'b1, 1'b0, 8'h81},  //                            R7 R8
      {8'h00, 1'b1, 1'b0, 1'b0, 8'h81}   //                            R3
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] prev_code;
      // Reset state
      #1;
      check(match == 1'b0, "R2 match in reset", match, 0);
      check(chg == 1'b0, "R2 chg in reset", chg, 0);
      @(posedge clk); #1;
      check(code == 8'h55, "R1 default code", code, 8'h55);
      check(match == 1'b0 && chg == 1'b0, "R2 flags held low", {match, chg}, 0);
      @(negedge clk);
      rst = 1'b0;
      prev_code = 8'h55;

      // Table walk
      for (int i = 0; i < NV; i++) begin
         sw  = VEC[i][18:11];
         key = VEC[i][10];
         #1;
         check(match == VEC[i][9], $sformatf("R3 match row %0d", i), match, VEC[i][9]);
         check(chg == VEC[i][8], $sformatf("R7 chg row %0d", i), chg, VEC[i][8]);
         check(code == prev_code, $sformatf("R10 code before edge row %0d", i), code, prev_code);
         @(posedge clk); #1;
         check(code == VEC[i][7:0], $sformatf("R4 R5 R6 R8 code row %0d", i), code, VEC[i][7:0]);
         prev_code = VEC[i][7:0];
         @(negedge clk);
      end

      // Reset against a load that would otherwise happen
      rst = 1'b1; sw = 8'h81; key = 1'b0;
      #1;
      check(match == 1'b0 && chg == 1'b0, "R2 flags low with matching switches", {match, chg}, 0);
      @(posedge clk); #1;
      check(code == 8'h55, "R9 reset wins over load", code, 8'h55);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check(match == 1'b0, "R9 no match after reset", match, 0);
      check(chg == 1'b0, "R9 session closed by reset", chg, 0);
      @(posedge clk); #1;
      check(code == 8'h55, "R9 held key cannot load", code, 8'h55);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule